// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block counts display lines for one transcoder and decides where each frame ends. It works in two modes. In fixed mode every frame has the same programmed total. In variable mode the vertical blank stretches: the frame ends at a point chosen between a programmed minimum and maximum line total, and that point depends on when software sends a push request. The block advances one line on each pulse of the line-start strobe. It drives the current line number, vertical blank, vertical sync, a frame-start pulse and a register-latch pulse. The latch pulse tells the rest of the pipe when double-buffered settings may take effect.

In variable mode, vblank exit begins at the first line on which the exit is allowed and a push is pending, or when the maximum decision boundary is reached. After the exit starts, the frame runs a fixed number of guardband lines and then wraps. The sync position is set as two offsets counted back from the end of the frame. Because the end of a variable frame is known only once the exit starts, the block computes the sync lines again for every frame. The minimum, maximum and flip-line totals are programmed as the count minus one. The mode bit is sampled only when a frame wraps. The configuration must give 1 <= active lines, an earliest exit line at or after the first blank line, a sync start offset no larger than the guardband, and a guardband of at least one line.

The controller has five states. ACTIVE holds the visible lines. FIXBLANK is the blank of a fixed-mode frame. HOLD is variable blank before the earliest exit line. WINDOW is variable blank between the two boundaries while no push is pending. GUARD runs the guardband lines after an exit. The transitions are:
- wrap: any state to ACTIVE when the last line of the frame passes.
- fixed-enter: ACTIVE to FIXBLANK at the first blank line.
- vrr-enter: ACTIVE to HOLD, WINDOW or GUARD at the first blank line, by the exit rule.
- open: HOLD to WINDOW on reaching the earliest exit line.
- exit: HOLD or WINDOW to GUARD when a push is pending inside the window, or on reaching the maximum boundary.

Top module: `vrr_vtiming`

## Requirements
- R1: While reset is held and after it is released, line_num is 0 and vblank, vsync, frame_start, latch_pulse, push_pending and vrr_live are all 0. The first line strobe after reset starts a frame: frame_start pulses with line_num 0.
- R2: In fixed mode a frame has cfg_vtotal_m1+1 lines, numbered from 0. latch_pulse is high for one clock when line cfg_vactive is entered. frame_start is high for one clock, only when the line number returns to 0.
- R3: vblank is 1 exactly on the lines numbered cfg_vactive or higher, in both modes.
- R4: In variable mode with no push, the frame has cfg_vmax_m1+1 lines. latch_pulse is raised on line cfg_vmax_m1+1-cfg_guard, which is the maximum decision boundary.
- R5: In variable mode, a push that becomes pending before the earliest exit line is held until that line. The exit starts there, and the frame total equals the minimum total. The minimum total is cfg_flip_m1+1 when cfg_flip_en is 1 and cfg_vmin_m1+1 when it is 0. The earliest exit line is the minimum total minus cfg_guard.
- R6: In variable mode, a push written while the counter sits on a line inside the window starts the exit on the next line entered, X. latch_pulse is raised on line X, and the frame has X+cfg_guard lines.
- R7: A push write with push_wr_en=1 and push_wr_send=1 sets push_pending. A push write with either bit 0 clears it. push_pending also clears when the exit begins.
- R8: Push writes are ignored while vrr_live is 0: push_pending stays 0 and the fixed frame length is unchanged.
- R9: vsync is 1 on the lines from T-cfg_vs_start_off up to but not including T-cfg_vs_end_off, where T is the total of the current frame.
- R10: cfg_vrr_en is sampled only when a frame wraps. vrr_live changes only together with frame_start, so a frame that is in progress keeps its mode when the bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-clock strobe at the start of each line |
| cfg_vrr_en | input | 1 | Variable refresh mode request |
| cfg_flip_en | input | 1 | Use the flip-line total as the minimum |
| cfg_vactive | input | LINE_W | Number of visible lines; first blank line |
| cfg_vtotal_m1 | input | LINE_W | Fixed-mode total minus one |
| cfg_vmin_m1 | input | LINE_W | Minimum total minus one |
| cfg_vmax_m1 | input | LINE_W | Maximum total minus one |
| cfg_flip_m1 | input | LINE_W | Flip-line total minus one |
| cfg_guard | input | LINE_W | Guardband lines after vblank exit |
| cfg_vs_start_off | input | LINE_W | Sync start, lines before frame end |
| cfg_vs_end_off | input | LINE_W | Sync end, lines before frame end |
| push_wr | input | 1 | Write strobe of the push register |
| push_wr_en | input | 1 | Enable bit of the push write |
| push_wr_send | input | 1 | Send bit of the push write |
| line_num | output | LINE_W | Current line number |
| vblank | output | 1 | Vertical blank |
| vsync | output | 1 | Vertical sync |
| frame_start | output | 1 | One-clock pulse when line 0 begins |
| latch_pulse | output | 1 | One-clock pulse when registers may latch |
| push_pending | output | 1 | Push send bit not yet consumed |
| vrr_live | output | 1 | Variable mode in effect for this frame |

## Verification
The bench checks fixed frames, frames with no push, and frames with one push, sweeping the push across every line from 0 up to the maximum boundary. The sweep runs once with the flip-line minimum and once with the plain minimum. Pushes before the earliest line must collapse onto that line, while pushes inside the window must move the end of the frame one line at a time, so the sweep tells a late-held push apart from one that is acted on at once. A set-then-cancel push pair, pushes made in fixed mode, and mode changes in mid-frame in both directions show that the pending bit and the mode switch change frame length only where the requirements allow.

// File: rtl/vrr_vtiming_pkg.sv
package vrr_vtiming_pkg;

    // Region of the frame the line counter is in.
    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_FIXBLANK = 3'd1,
        ST_HOLD     = 3'd2,
        ST_WINDOW   = 3'd3,
        ST_GUARD    = 3'd4
    } vt_state_e;

endpackage

// File: rtl/vrr_push_ctl.sv
module vrr_push_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic wr_i,
    input  logic wr_en_i,
    input  logic wr_send_i,
    input  logic consume_i,
    output logic pending_o
);

    // A write replaces the send bit; the exit consumes it; fixed mode keeps it clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_o <= 1'b0;
        end else if (!live_i) begin
            pending_o <= 1'b0;
        end else if (wr_i) begin
            pending_o <= wr_en_i & wr_send_i;
        end else if (consume_i) begin
            pending_o <= 1'b0;
        end
    end

    // R7: an exit with no competing write leaves no push behind
    p_exit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !wr_i) |=> !pending_o);

endmodule

// File: rtl/vrr_frame_fsm.sv
module vrr_frame_fsm
    import vrr_vtiming_pkg::*;
#(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cfg_vrr_en_i,
    input  logic              cfg_flip_en_i,
    input  logic [LINE_W-1:0] cfg_vactive_i,
    input  logic [LINE_W-1:0] cfg_vtotal_m1_i,
    input  logic [LINE_W-1:0] cfg_vmin_m1_i,
    input  logic [LINE_W-1:0] cfg_vmax_m1_i,
    input  logic [LINE_W-1:0] cfg_flip_m1_i,
    input  logic [LINE_W-1:0] cfg_guard_i,
    input  logic              pending_i,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] line_n_o,
    output logic [LINE_W-1:0] last_n_o,
    output logic              wrap_o,
    output logic              exit_o,
    output logic              fix_latch_o,
    output logic              live_o
);

    localparam int unsigned SUM_W = LINE_W + 1;

    vt_state_e         state_q, state_n;
    logic [LINE_W-1:0] line_q, line_n;
    logic [LINE_W-1:0] last_q, last_n;
    logic              live_q, live_n;
    logic              wrap_c, exit_c, fix_c;

    logic [LINE_W-1:0] incr;
    logic [LINE_W-1:0] exit_last;
    logic [SUM_W-1:0]  min_tot, max_tot, reach;
    logic              past_min, at_max, vrr_go;
    vt_state_e         vrr_next;

    // Totals carry one extra bit so that line + guard never wraps.
    assign min_tot   = cfg_flip_en_i ? ({1'b0, cfg_flip_m1_i} + SUM_W'(1))
                                     : ({1'b0, cfg_vmin_m1_i} + SUM_W'(1));
    assign max_tot   = {1'b0, cfg_vmax_m1_i} + SUM_W'(1);
    assign incr      = line_q + LINE_W'(1);
    assign reach     = {1'b0, incr} + {1'b0, cfg_guard_i};
    assign past_min  = (reach >= min_tot);
    assign at_max    = (reach >= max_tot);
    assign vrr_go    = past_min && (pending_i || at_max);
    assign exit_last = incr + cfg_guard_i - LINE_W'(1);

    always_comb begin
        if (vrr_go) begin
            vrr_next = ST_GUARD;
        end else if (past_min) begin
            vrr_next = ST_WINDOW;
        end else begin
            vrr_next = ST_HOLD;
        end
    end

    // Next-state and next-line decision, evaluated for the coming line strobe.
    always_comb begin
        wrap_c  = (line_q == last_q);
        line_n  = incr;
        state_n = state_q;
        last_n  = last_q;
        live_n  = live_q;
        exit_c  = 1'b0;
        fix_c   = 1'b0;
        if (wrap_c) begin
            line_n  = '0;
            live_n  = cfg_vrr_en_i;
            last_n  = cfg_vrr_en_i ? cfg_vmax_m1_i : cfg_vtotal_m1_i;
            state_n = ST_ACTIVE;
        end else begin
            unique case (state_q)
                ST_ACTIVE: begin
                    if (incr == cfg_vactive_i) begin
                        if (live_q) begin
                            state_n = vrr_next;
                            exit_c  = vrr_go;
                            if (vrr_go) begin
                                last_n = exit_last;
                            end
                        end else begin
                            state_n = ST_FIXBLANK;
                            fix_c   = 1'b1;
                        end
                    end
                end
                ST_HOLD, ST_WINDOW: begin
                    state_n = vrr_next;
                    exit_c  = vrr_go;
                    if (vrr_go) begin
                        last_n = exit_last;
                    end
                end
                ST_FIXBLANK, ST_GUARD: begin
                    state_n = state_q;
                end
                default: begin
                    state_n = ST_ACTIVE;
                end
            endcase
        end
    end

    // State register: everything moves only on a line strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            line_q  <= '0;
            last_q  <= '0;
            live_q  <= 1'b0;
        end else if (tick_i) begin
            state_q <= state_n;
            line_q  <= line_n;
            last_q  <= last_n;
            live_q  <= live_n;
        end
    end

    assign line_o      = line_q;
    assign line_n_o    = line_n;
    assign last_n_o    = last_n;
    assign wrap_o      = tick_i & wrap_c;
    assign exit_o      = tick_i & exit_c;
    assign fix_latch_o = tick_i & fix_c;
    assign live_o      = live_q;

    // R2: the counter never passes the last line of the frame it is in
    p_line_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= last_q);

    // R5: HOLD is only ever occupied before the earliest exit line
    p_hold_below_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (({1'b0, line_q} + {1'b0, cfg_guard_i}) < min_tot));

    // R4: no variable blank line reaches the maximum decision boundary without exiting
    p_below_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD || state_q == ST_WINDOW)
            |-> (({1'b0, line_q} + {1'b0, cfg_guard_i}) < max_tot));

endmodule

// File: rtl/vrr_sync_gen.sv
module vrr_sync_gen #(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wrap_i,
    input  logic              latch_i,
    input  logic [LINE_W-1:0] line_n_i,
    input  logic [LINE_W-1:0] last_n_i,
    input  logic [LINE_W-1:0] cfg_vactive_i,
    input  logic [LINE_W-1:0] cfg_vs_start_i,
    input  logic [LINE_W-1:0] cfg_vs_end_i,
    output logic              vblank_o,
    output logic              vsync_o,
    output logic              frame_start_o,
    output logic              latch_o
);

    localparam int unsigned SUM_W = LINE_W + 1;

    logic [SUM_W-1:0] tot, lo_reach, hi_reach;
    logic             vs_on, vb_on;

    // Sync lines are placed relative to the end of the coming frame,
    // which is known once the exit line has been chosen.
    assign tot      = {1'b0, last_n_i} + SUM_W'(1);
    assign lo_reach = {1'b0, line_n_i} + {1'b0, cfg_vs_start_i};
    assign hi_reach = {1'b0, line_n_i} + {1'b0, cfg_vs_end_i};
    assign vs_on    = (lo_reach >= tot) && (hi_reach < tot);
    assign vb_on    = (line_n_i >= cfg_vactive_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vblank_o      <= 1'b0;
            vsync_o       <= 1'b0;
            frame_start_o <= 1'b0;
            latch_o       <= 1'b0;
        end else begin
            frame_start_o <= wrap_i;
            latch_o       <= latch_i;
            if (tick_i) begin
                vblank_o <= vb_on;
                vsync_o  <= vs_on;
            end
        end
    end

    // R9: sync always sits inside the blank
    p_vsync_in_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o |-> vblank_o);

    // R2: the frame-start pulse lasts one clock
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming #(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              cfg_vrr_en,
    input  logic              cfg_flip_en,
    input  logic [LINE_W-1:0] cfg_vactive,
    input  logic [LINE_W-1:0] cfg_vtotal_m1,
    input  logic [LINE_W-1:0] cfg_vmin_m1,
    input  logic [LINE_W-1:0] cfg_vmax_m1,
    input  logic [LINE_W-1:0] cfg_flip_m1,
    input  logic [LINE_W-1:0] cfg_guard,
    input  logic [LINE_W-1:0] cfg_vs_start_off,
    input  logic [LINE_W-1:0] cfg_vs_end_off,
    input  logic              push_wr,
    input  logic              push_wr_en,
    input  logic              push_wr_send,
    output logic [LINE_W-1:0] line_num,
    output logic              vblank,
    output logic              vsync,
    output logic              frame_start,
    output logic              latch_pulse,
    output logic              push_pending,
    output logic              vrr_live
);

    logic [LINE_W-1:0] line_n, last_n;
    logic              wrap, exit_go, fix_latch;

    vrr_frame_fsm #(
        .LINE_W (LINE_W)
    ) fsm_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (line_tick),
        .cfg_vrr_en_i    (cfg_vrr_en),
        .cfg_flip_en_i   (cfg_flip_en),
        .cfg_vactive_i   (cfg_vactive),
        .cfg_vtotal_m1_i (cfg_vtotal_m1),
        .cfg_vmin_m1_i   (cfg_vmin_m1),
        .cfg_vmax_m1_i   (cfg_vmax_m1),
        .cfg_flip_m1_i   (cfg_flip_m1),
        .cfg_guard_i     (cfg_guard),
        .pending_i       (push_pending),
        .line_o          (line_num),
        .line_n_o        (line_n),
        .last_n_o        (last_n),
        .wrap_o          (wrap),
        .exit_o          (exit_go),
        .fix_latch_o     (fix_latch),
        .live_o          (vrr_live)
    );

    vrr_push_ctl push_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_i    (vrr_live),
        .wr_i      (push_wr),
        .wr_en_i   (push_wr_en),
        .wr_send_i (push_wr_send),
        .consume_i (exit_go),
        .pending_o (push_pending)
    );

    vrr_sync_gen #(
        .LINE_W (LINE_W)
    ) sync_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (line_tick),
        .wrap_i         (wrap),
        .latch_i        (exit_go | fix_latch),
        .line_n_i       (line_n),
        .last_n_i       (last_n),
        .cfg_vactive_i  (cfg_vactive),
        .cfg_vs_start_i (cfg_vs_start_off),
        .cfg_vs_end_i   (cfg_vs_end_off),
        .vblank_o       (vblank),
        .vsync_o        (vsync),
        .frame_start_o  (frame_start),
        .latch_o        (latch_pulse)
    );

    // R2: a new frame always begins on line 0
    p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_num == '0));

    // R10: the live mode moves only together with a frame start
    p_live_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vrr_live != $past(vrr_live)) |-> frame_start);

    // R8: in fixed mode no push can be left pending
    p_offline_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vrr_live |=> !push_pending);

endmodule

// File: tb/vrr_vtiming_tb_top.sv
module vrr_vtiming_tb_top;

    localparam int LW   = 12;
    localparam int VACT = 6;
    localparam int VTOT = 12;
    localparam int VMIN = 12;
    localparam int FLIP = 14;
    localparam int VMAX = 20;
    localparam int GB   = 4;
    localparam int VSS  = 3;
    localparam int VSE  = 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, line_tick, en, flip_en;
    logic          push_wr, push_wr_en, push_wr_send;
    logic [LW-1:0] line_num;
    logic          vblank, vsync, frame_start, latch_pulse, push_pending, vrr_live;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    vrr_vtiming #(.LINE_W(LW)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .line_tick        (line_tick),
        .cfg_vrr_en       (en),
        .cfg_flip_en      (flip_en),
        .cfg_vactive      (LW'(VACT)),
        .cfg_vtotal_m1    (LW'(VTOT - 1)),
        .cfg_vmin_m1      (LW'(VMIN - 1)),
        .cfg_vmax_m1      (LW'(VMAX - 1)),
        .cfg_flip_m1      (LW'(FLIP - 1)),
        .cfg_guard        (LW'(GB)),
        .cfg_vs_start_off (LW'(VSS)),
        .cfg_vs_end_off   (LW'(VSE)),
        .push_wr          (push_wr),
        .push_wr_en       (push_wr_en),
        .push_wr_send     (push_wr_send),
        .line_num         (line_num),
        .vblank           (vblank),
        .vsync            (vsync),
        .frame_start      (frame_start),
        .latch_pulse      (latch_pulse),
        .push_pending     (push_pending),
        .vrr_live         (vrr_live)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL all requirements watchdog: actual %0d cycles expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    task automatic do_push(input bit wen, input bit wsend);
        @(negedge clk);
        push_wr = 1'b1; push_wr_en = wen; push_wr_send = wsend;
        @(negedge clk);
        push_wr = 1'b0; push_wr_en = 1'b0; push_wr_send = 1'b0;
    endtask

    // Runs one frame starting on line 0 and checks its length, latch line, blank and sync.
    task automatic run_frame(input string req, input int push_line, input int cancel_line,
                             input int chg_line, input bit chg_val,
                             input int exp_t, input int exp_lat,
                             output bit pend_seen, output bit pend_after, output bit live_bad);
        int n = 0;
        int lat = -1;
        int vs_first = -1;
        int vs_cnt = 0;
        int vb_bad = 0;
        int ln_bad = 0;
        bit live0 = vrr_live;
        pend_seen = 1'b0; pend_after = 1'b0; live_bad = 1'b0;
        forever begin
            if (int'(line_num) != n) ln_bad++;
            if (vblank != (n >= VACT)) vb_bad++;
            if (latch_pulse && lat < 0) lat = n;
            if (vsync) begin
                if (vs_first < 0) vs_first = n;
                vs_cnt++;
            end
            if (vrr_live != live0) live_bad = 1'b1;
            if (push_pending) pend_seen = 1'b1;
            if (n == push_line) begin
                do_push(1'b1, 1'b1);
                pend_after = push_pending;
                if (push_pending) pend_seen = 1'b1;
            end
            if (n == cancel_line) begin
                do_push(1'b1, 1'b0);
                pend_after = push_pending;
            end
            if (n == chg_line) en = chg_val;
            step();
            if (frame_start || n >= 100) break;
            n++;
        end
        chk(req, "frame length", n + 1, exp_t);
        chk(req, "latch line", lat, exp_lat);
        chk(req, "line numbering mismatches", ln_bad, 0);
        chk("R3", "vblank mismatches", vb_bad, 0);
        chk("R9", "vsync first line", vs_first, exp_t - VSS);
        chk("R9", "vsync line count", vs_cnt, VSS - VSE);
        chk("R7", "pending at frame end", int'(push_pending), 0);
    endtask

    initial begin
        bit ps, pa, lb;
        rst_n = 1'b0; line_tick = 1'b0; en = 1'b0; flip_en = 1'b0;
        push_wr = 1'b0; push_wr_en = 1'b0; push_wr_send = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "line in reset", int'(line_num), 0);
        chk("R1", "live in reset", int'(vrr_live), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset",
            int'({vblank, vsync, frame_start, latch_pulse, push_pending, vrr_live}), 0);
        step();
        chk("R1", "frame start on first strobe", int'(frame_start), 1);
        chk("R1", "line after first strobe", int'(line_num), 0);

        // R2: plain fixed frame
        run_frame("R2", -1, -1, -1, 1'b0, VTOT, VACT, ps, pa, lb);
        // R8: push in fixed mode is ignored
        run_frame("R8", 2, -1, -1, 1'b0, VTOT, VACT, ps, pa, lb);
        chk("R8", "pending seen in fixed mode", int'(ps), 0);
        // R10: enabling mid-frame leaves this frame fixed
        run_frame("R10", -1, -1, 3, 1'b1, VTOT, VACT, ps, pa, lb);
        chk("R10", "live changed mid-frame", int'(lb), 0);
        chk("R10", "live after boundary", int'(vrr_live), 1);
        // R4: no push, frame runs to the maximum
        run_frame("R4", -1, -1, -1, 1'b1, VMAX, VMAX - GB, ps, pa, lb);

        // R5 and R6: push swept over every line, plain minimum then flip-line minimum
        for (int f = 0; f < 2; f++) begin
            flip_en = (f == 1);
            for (int k = 0; k < VMAX - GB; k++) begin
                int e;
                int x;
                string r;
                e = ((f == 1) ? FLIP : VMIN) - GB;
                x = (k + 1 > e) ? k + 1 : e;
                r = (k + 1 <= e) ? "R5" : "R6";
                run_frame(r, k, -1, -1, 1'b1, x + GB, x, ps, pa, lb);
                chk("R7", "pending after send write", int'(pa), 1);
            end
        end

        // R7: a write with the send bit clear cancels the push
        run_frame("R7", 2, 3, -1, 1'b1, VMAX, VMAX - GB, ps, pa, lb);
        chk("R7", "pending after cancel write", int'(pa), 0);
        // R10: disabling mid-frame keeps this frame variable
        run_frame("R10", -1, -1, 3, 1'b0, VMAX, VMAX - GB, ps, pa, lb);
        chk("R10", "live changed mid-frame", int'(lb), 0);
        chk("R10", "live after boundary", int'(vrr_live), 0);
        run_frame("R10", -1, -1, -1, 1'b0, VTOT, VACT, ps, pa, lb);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule